// File: doc/BRIEF.md
# Flash Byte Program Sequencer

This block programs a run of bytes into one 64 KiB block of a byte-wide flash device and then reads every byte back to confirm it. A start pulse supplies a byte address and a byte count. The block trims the count so that the run stays inside the addressed block and fits the internal buffer. It then takes the data bytes one at a time over a valid/ready stream. Each byte is kept in an internal buffer, so the verify pass does not need the data sent a second time.

For every byte the sequencer drives a fixed bus sequence on the flash port. It makes a throw-away read of the status location and latches the byte-lane select from the two low address bits. It writes the program command and then the data byte to the word-aligned address, requests status, and polls until the device reports ready. Two retry paths exist. A poll that runs past the per-byte limit clears status and restarts the byte. A program error reported in status clears status, waits a short gap, and restarts the byte. Both paths end with a timeout error once the block-level timer has expired. When the run finishes, a one-cycle done pulse carries the result: the number of bytes written with code 0, or a count of zero with an error code.

Top module: `flash_prog_seq`

## Requirements
- R1: The number of bytes programmed is the smallest of `byte_cnt`, 0x10000 minus `start_addr[15:0]`, and `BUF_DEPTH`. A successful run reports that number on `done_cnt`.
- R2: Each byte's sequence begins with a read of `STAT_ADDR` (0x8000). In the same cycle, `fl_lane` is loaded with bits [1:0] of the target byte address, and it holds that value through the command and data writes.
- R3: The program command 0x40 is written, and in the next cycle the data byte is written. Both writes go to the target address with bits [1:0] forced to zero.
- R4: After the data write, 0x70 is written to `SREQ_ADDR` (0x10000). In the next cycle polling starts: repeated reads of `STAT_ADDR` until bit 7 of `fl_rdata` is 1.
- R5: If ready is not seen within `BYTE_TMO` poll cycles, 0x50 is written to `STAT_ADDR` and the byte is restarted from its first read. No 0xFF write is made on this path.
- R6: In the cycle after a poll read that shows bit 7 set, 0xFF is written to `STAT_ADDR`.
- R7: If that status also has bit 4 set, 0x50 is written to `STAT_ADDR`, the block waits about `RETRY_DLY` cycles, and then the byte is retried. If the block timer (`BLOCK_TMO` cycles from start) has expired at a status clear, the run ends with `done_err` = 1 and `done_cnt` = 0.
- R8: After programming, each byte is read back at its own address and compared with the buffered data. Any mismatch ends the run with `done_err` = 2 and `done_cnt` = 0. If every byte matches, the result is `done_err` = 0.
- R9: If the trimmed count is zero, `done` pulses without any flash cycle, with `done_cnt` = 0 and `done_err` = 0.
- R10: `start` is ignored while `busy` is high. A second request during a run does not change that run's bytes or its result.
- R11: `in_ready` is high only while the block waits for the next byte, and exactly one byte is taken per programmed byte. `fl_wr` and `fl_rd` are never both high. `done` lasts one cycle.
- R12: After reset, `busy`, `done`, `in_ready`, `fl_wr` and `fl_rd` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| start_addr | input | ADDR_W | Byte address of the first byte |
| byte_cnt | input | CNT_W | Requested byte count |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Stream byte accepted when high with in_valid |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wr | output | 1 | Flash write strobe |
| fl_rd | output | 1 | Flash read strobe |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid in the cycle of fl_rd |
| fl_lane | output | 2 | Byte-lane select for program data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| done_cnt | output | CNT_W | Bytes written, 0 on error |
| done_err | output | 2 | 0 ok, 1 timeout, 2 verify mismatch |

## Verification
On every cycle, the assertions check the local bus ordering. The data write follows the command at the same aligned address, the lane select holds across it, and polling follows the status request. A ready status is followed by the return to read mode, reads and writes never overlap, and done is a single pulse that carries a count within the clamp. Other behaviours show only in the bench's scenarios, which use a flash model with injected hangs, program errors and corrupted cells. These are: the clamp at the block end and at the buffer depth, the restart after a poll timeout, the error retries up to the block-level timeout, verify failures, the zero-count run, and a start request made while busy.

// File: rtl/fps_pkg.sv
// Shared types and bus constants for the flash byte program sequencer.
// Assumes a byte-wide flash with a status-read command set.
package fps_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_DUMMY, S_CMD, S_DATA, S_SREQ, S_POLL,
        S_TCLR, S_RDMODE, S_ECLR, S_WAIT, S_VERIFY, S_DONE
    } fps_state_e;

    localparam logic [7:0] OP_PROG  = 8'h40;
    localparam logic [7:0] OP_STAT  = 8'h70;
    localparam logic [7:0] OP_CLR   = 8'h50;
    localparam logic [7:0] OP_READ  = 8'hFF;

    localparam logic [1:0] RES_OK  = 2'd0;
    localparam logic [1:0] RES_TMO = 2'd1;
    localparam logic [1:0] RES_VFY = 2'd2;
endpackage

// File: rtl/fps_timer.sv
// Saturating cycle counter that flags when LIMIT enabled cycles have passed.
// Assumes LIMIT >= 1; clr has priority over en.
module fps_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt_q;

    // Count enabled cycles up to LIMIT and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (en && cnt_q != CW'(LIMIT))
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/fps_buf.sv
// Byte buffer holding the streamed data for the verify pass.
// Assumes DEPTH is a power of two; read is asynchronous.
module fps_buf #(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/flash_prog_seq.sv
// Programs a clamped run of bytes into one 64 KiB flash block, byte by byte,
// with poll and error retries bounded by per-byte and per-block timers, then
// reads every byte back against the buffered data.
// Assumes fl_rdata is valid in the same cycle as fl_rd.
module flash_prog_seq
    import fps_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 17,
    parameter int BUF_DEPTH = 256,
    parameter int BYTE_TMO  = 1000,
    parameter int BLOCK_TMO = 30000,
    parameter int RETRY_DLY = 100,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'('h8000),
    parameter logic [ADDR_W-1:0] SREQ_ADDR = ADDR_W'('h10000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_wr,
    output logic              fl_rd,
    output logic [7:0]        fl_wdata,
    input  logic [7:0]        fl_rdata,
    output logic [1:0]        fl_lane,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  done_cnt,
    output logic [1:0]        done_err
);
    localparam int BUF_AW = $clog2(BUF_DEPTH);

    fps_state_e        state_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  n_q, idx_q;
    logic [7:0]        byte_q;
    logic              perr_q;
    logic [1:0]        lane_q;
    logic [CNT_W-1:0]  res_cnt_q;
    logic [1:0]        res_err_q;
    logic [31:0]       room_w, eff_w;
    logic [ADDR_W-1:0] cur_addr, word_addr;
    logic              last_byte, poll_exp, blk_exp, wait_exp;
    logic [7:0]        buf_rd;

    // Trim the requested count to the block end and to the buffer depth.
    always_comb begin
        room_w = 32'h0001_0000 - {16'd0, start_addr[15:0]};
        eff_w  = 32'(byte_cnt);
        if (room_w < eff_w)
            eff_w = room_w;
        if (32'(BUF_DEPTH) < eff_w)
            eff_w = 32'(BUF_DEPTH);
    end

    assign cur_addr  = base_q + ADDR_W'(idx_q);
    assign word_addr = {cur_addr[ADDR_W-1:2], 2'b00};
    assign last_byte = (idx_q == n_q - CNT_W'(1));

    fps_timer #(.LIMIT(BYTE_TMO)) u_poll_tmr (
        .clk(clk), .rst_n(rst_n), .clr(state_q == S_SREQ),
        .en(state_q == S_POLL), .expired(poll_exp));

    fps_timer #(.LIMIT(BLOCK_TMO)) u_blk_tmr (
        .clk(clk), .rst_n(rst_n), .clr(state_q == S_IDLE),
        .en(1'b1), .expired(blk_exp));

    fps_timer #(.LIMIT(RETRY_DLY)) u_wait_tmr (
        .clk(clk), .rst_n(rst_n), .clr(state_q == S_ECLR),
        .en(state_q == S_WAIT), .expired(wait_exp));

    fps_buf #(.DEPTH(BUF_DEPTH), .AW(BUF_AW)) u_buf (
        .clk(clk), .we(state_q == S_FETCH && in_valid),
        .waddr(idx_q[BUF_AW-1:0]), .wdata(in_data),
        .raddr(idx_q[BUF_AW-1:0]), .rdata(buf_rd));

    // Drive the flash bus according to the current step of the sequence.
    always_comb begin
        fl_wr    = 1'b0;
        fl_rd    = 1'b0;
        fl_addr  = STAT_ADDR;
        fl_wdata = OP_READ;
        unique case (state_q)
            S_DUMMY:  fl_rd = 1'b1;
            S_CMD:    begin fl_wr = 1'b1; fl_addr = word_addr; fl_wdata = OP_PROG; end
            S_DATA:   begin fl_wr = 1'b1; fl_addr = word_addr; fl_wdata = byte_q; end
            S_SREQ:   begin fl_wr = 1'b1; fl_addr = SREQ_ADDR; fl_wdata = OP_STAT; end
            S_POLL:   fl_rd = 1'b1;
            S_TCLR,
            S_ECLR:   begin fl_wr = 1'b1; fl_wdata = OP_CLR; end
            S_RDMODE: fl_wr = 1'b1;
            S_VERIFY: begin fl_rd = 1'b1; fl_addr = cur_addr; end
            default:  ;
        endcase
    end

    // Sequence state, byte index and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            base_q    <= '0;
            n_q       <= '0;
            idx_q     <= '0;
            byte_q    <= '0;
            perr_q    <= 1'b0;
            lane_q    <= '0;
            res_cnt_q <= '0;
            res_err_q <= RES_OK;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    base_q <= start_addr;
                    n_q    <= CNT_W'(eff_w);
                    idx_q  <= '0;
                    if (eff_w == 32'd0) begin
                        res_cnt_q <= '0;
                        res_err_q <= RES_OK;
                        state_q   <= S_DONE;
                    end else begin
                        state_q <= S_FETCH;
                    end
                end
                S_FETCH: if (in_valid) begin
                    byte_q  <= in_data;
                    state_q <= S_DUMMY;
                end
                S_DUMMY: begin
                    lane_q  <= cur_addr[1:0];
                    state_q <= S_CMD;
                end
                S_CMD:  state_q <= S_DATA;
                S_DATA: state_q <= S_SREQ;
                S_SREQ: state_q <= S_POLL;
                S_POLL: begin
                    if (fl_rdata[7]) begin
                        perr_q  <= fl_rdata[4];
                        state_q <= S_RDMODE;
                    end else if (poll_exp) begin
                        state_q <= S_TCLR;
                    end
                end
                S_TCLR, S_ECLR: begin
                    if (blk_exp) begin
                        res_cnt_q <= '0;
                        res_err_q <= RES_TMO;
                        state_q   <= S_DONE;
                    end else begin
                        state_q <= (state_q == S_TCLR) ? S_DUMMY : S_WAIT;
                    end
                end
                S_RDMODE: begin
                    if (perr_q) begin
                        state_q <= S_ECLR;
                    end else if (last_byte) begin
                        idx_q   <= '0;
                        state_q <= S_VERIFY;
                    end else begin
                        idx_q   <= idx_q + CNT_W'(1);
                        state_q <= S_FETCH;
                    end
                end
                S_WAIT: if (wait_exp) state_q <= S_DUMMY;
                S_VERIFY: begin
                    if (fl_rdata != buf_rd) begin
                        res_cnt_q <= '0;
                        res_err_q <= RES_VFY;
                        state_q   <= S_DONE;
                    end else if (last_byte) begin
                        res_cnt_q <= n_q;
                        res_err_q <= RES_OK;
                        state_q   <= S_DONE;
                    end else begin
                        idx_q <= idx_q + CNT_W'(1);
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign in_ready = (state_q == S_FETCH);
    assign busy     = (state_q != S_IDLE);
    assign done     = (state_q == S_DONE);
    assign fl_lane  = lane_q;
    assign done_cnt = res_cnt_q;
    assign done_err = res_err_q;
endmodule

// File: rtl/flash_prog_seq_chk.sv
// Cycle-level protocol checks for flash_prog_seq, attached by bind.
// Assumes the sequencer state is visible through the bind connection.
module flash_prog_seq_chk
    import fps_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 17,
    parameter int BUF_DEPTH = 256,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'('h8000),
    parameter logic [ADDR_W-1:0] SREQ_ADDR = ADDR_W'('h10000)
) (
    input logic              clk,
    input logic              rst_n,
    input fps_state_e        state,
    input logic              fl_wr,
    input logic              fl_rd,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_wdata,
    input logic [7:0]        fl_rdata,
    input logic [1:0]        fl_lane,
    input logic              in_ready,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  done_cnt,
    input logic [1:0]        done_err
);
    p_no_rdwr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_wr && fl_rd));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

    p_poll_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_wr && fl_addr == SREQ_ADDR) |=> (fl_rd && fl_addr == STAT_ADDR));

    p_data_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CMD) |=> (fl_wr && fl_addr == $past(fl_addr) && fl_addr[1:0] == 2'b00));

    p_lane_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA) |-> $stable(fl_lane));

    p_read_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POLL && fl_rdata[7]) |=> (fl_wr && fl_wdata == 8'hFF && fl_addr == STAT_ADDR));

    p_clamp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err == 2'd0) |-> (done_cnt <= CNT_W'(BUF_DEPTH)));

    p_vfy_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err == 2'd2) |-> (done_cnt == '0));
endmodule

bind flash_prog_seq flash_prog_seq_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUF_DEPTH(BUF_DEPTH),
    .STAT_ADDR(STAT_ADDR), .SREQ_ADDR(SREQ_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .fl_wr(fl_wr), .fl_rd(fl_rd),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_lane(fl_lane),
    .in_ready(in_ready), .busy(busy), .done(done), .done_cnt(done_cnt),
    .done_err(done_err)
);

// File: tb/tb_flash_prog_seq.sv
`timescale 1ns/1ps
module tb_flash_prog_seq;
    localparam int ADDR_W = 24, CNT_W = 17, DEPTH = 256;
    localparam int BYTE_TMO = 20, BLOCK_TMO = 3000, RETRY_DLY = 4, PDLY = 3;
    localparam int NV = 5;
    localparam int VADDR [NV] = '{32'h030100, 32'h04FFFC, 32'h050003, 32'h060000, 32'h07FFFF};
    localparam int VCNT  [NV] = '{5, 10, 6, 300, 3};
    localparam int VEXP  [NV] = '{5, 4, 6, 256, 1};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b1;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  byte_cnt = '0;
    logic [7:0] in_data, fl_wdata, fl_rdata;
    logic in_ready, fl_wr, fl_rd, busy, done;
    logic [ADDR_W-1:0] fl_addr;
    logic [1:0] fl_lane, done_err;
    logic [CNT_W-1:0] done_cnt;

    always #10 clk = ~clk;

    flash_prog_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUF_DEPTH(DEPTH),
        .BYTE_TMO(BYTE_TMO), .BLOCK_TMO(BLOCK_TMO), .RETRY_DLY(RETRY_DLY)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_cnt(byte_cnt), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .fl_addr(fl_addr), .fl_wr(fl_wr), .fl_rd(fl_rd),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_lane(fl_lane), .busy(busy),
        .done(done), .done_cnt(done_cnt), .done_err(done_err));

    int nchk = 0, nfail = 0;
    int sent = 0, sent0 = 0, seed = 0;
    int hang_at = -1, err_lo = 0, err_hi = 0, corrupt_at = -1;

    function automatic logic [7:0] pat(input int k, input int s);
        return 8'(k * 29 + s);
    endfunction

    always_comb in_data = pat(sent - sent0, seed);

    // Flash model: command decode, status with busy/err, byte array.
    logic [7:0] mem [1024];
    logic stat_mode = 1'b0, pend = 1'b0, stat_err = 1'b0;
    int busy_cnt = 0, n_prog = 0, n_clr = 0, n_ff = 0, n_sreq = 0, n_dummy = 0;
    int n_bad = 0, n_ops = 0;
    initial for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;

    always @(posedge clk) begin
        if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        if (fl_rd || fl_wr) n_ops <= n_ops + 1;
        if (fl_rd && fl_addr == 24'h008000 && !stat_mode) n_dummy <= n_dummy + 1;
        if (fl_wr) begin
            if (pend) begin
                pend <= 1'b0;
                n_prog <= n_prog + 1;
                if (fl_addr[1:0] != 2'b00) n_bad <= n_bad + 1;
                mem[{fl_addr[9:2], fl_lane}] <= (n_prog == corrupt_at) ? ~fl_wdata : fl_wdata;
                busy_cnt <= (n_prog == hang_at) ? 1000 : PDLY;
                stat_err <= (n_prog >= err_lo && n_prog < err_hi);
            end else begin
                case (fl_wdata)
                    8'h40: begin pend <= 1'b1; if (fl_addr[1:0] != 2'b00) n_bad <= n_bad + 1; end
                    8'h70: begin stat_mode <= 1'b1; if (fl_addr == 24'h010000) n_sreq <= n_sreq + 1; end
                    8'h50: begin stat_err <= 1'b0; n_clr <= n_clr + 1; end
                    8'hFF: begin stat_mode <= 1'b0; n_ff <= n_ff + 1; end
                    default: n_bad <= n_bad + 1;
                endcase
            end
        end
    end
    assign fl_rdata = stat_mode ? {(busy_cnt == 0), 2'b00, stat_err, 4'b0000} : mem[fl_addr[9:0]];

    // Stream feeder: count one byte per handshake.
    initial begin
        logic hs;
        forever begin
            @(negedge clk); hs = in_valid && in_ready;
            @(posedge clk); #1;
            if (hs) sent = sent + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    int r_err, r_cnt, r_cyc;
    task automatic run(input int a, input int c, input int s, input int dup_at);
        int k;
        seed = s;
        sent0 = sent;
        @(negedge clk);
        start_addr = ADDR_W'(a); byte_cnt = CNT_W'(c); start = 1'b1;
        @(negedge clk); start = 1'b0;
        k = 0;
        while (!done && k < 20000) begin
            @(negedge clk); k++;
            if (k == dup_at) begin
                start_addr = 24'h0B0000; byte_cnt = 9; start = 1'b1;
            end else start = 1'b0;
        end
        start = 1'b0;
        r_err = int'(done_err); r_cnt = int'(done_cnt); r_cyc = k;
        chk(done == 1'b1, "R11 done seen", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R11 done one cycle", int'(done), 0);
    endtask

    task automatic mem_ok(input int a, input int n, input int s, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++)
            if (mem[10'(a + i)] != pat(i, s)) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        #(200000 * 20);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int p0, c0, f0, q0, d0, o0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!busy && !done && !in_ready && !fl_wr && !fl_rd, "R12 reset outputs",
            int'({busy, done, in_ready, fl_wr, fl_rd}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R12 idle after reset", int'({busy, done}), 0);

        // Table of runs: R1 clamp, R2 lanes, R3..R6 bus sequence, R8 verify pass
        for (int v = 0; v < NV; v++) begin
            p0 = n_prog; f0 = n_ff; q0 = n_sreq; d0 = n_dummy;
            run(VADDR[v], VCNT[v], v * 17 + 3, 0);
            chk(r_err == 0, "R8 no error", r_err, 0);
            chk(r_cnt == VEXP[v], "R1 clamped count", r_cnt, VEXP[v]);
            chk(n_prog - p0 == VEXP[v], "R1 programs issued", n_prog - p0, VEXP[v]);
            chk(sent - sent0 == VEXP[v], "R11 bytes taken", sent - sent0, VEXP[v]);
            mem_ok(VADDR[v], VEXP[v], v * 17 + 3, "R2 lane/data placed");
            chk(n_sreq - q0 == VEXP[v], "R4 status requests", n_sreq - q0, VEXP[v]);
            chk(n_ff - f0 == VEXP[v], "R6 read-mode writes", n_ff - f0, VEXP[v]);
            chk(n_dummy - d0 == VEXP[v], "R2 dummy reads", n_dummy - d0, VEXP[v]);
        end
        chk(n_bad == 0, "R3 aligned command/data", n_bad, 0);

        // R9 zero count after clamp
        o0 = n_ops;
        run(32'h010000, 0, 1, 0);
        chk(r_err == 0 && r_cnt == 0, "R9 zero result", r_cnt, 0);
        chk(n_ops == o0, "R9 no flash cycles", n_ops - o0, 0);

        // R5 poll timeout restart
        p0 = n_prog; c0 = n_clr; f0 = n_ff; hang_at = n_prog;
        run(32'h020010, 2, 41, 0);
        hang_at = -1;
        chk(r_err == 0 && r_cnt == 2, "R5 result after restart", r_cnt, 2);
        chk(n_prog - p0 == 3, "R5 byte reprogrammed", n_prog - p0, 3);
        chk(n_clr - c0 == 1, "R5 status cleared", n_clr - c0, 1);
        chk(n_ff - f0 == 2, "R5 no read-mode on timeout", n_ff - f0, 2);
        mem_ok(32'h020010, 2, 41, "R5 data");

        // R7 program error retries
        p0 = n_prog; c0 = n_clr; err_lo = n_prog; err_hi = n_prog + 2;
        run(32'h020040, 3, 55, 0);
        chk(r_err == 0 && r_cnt == 3, "R7 result after retries", r_cnt, 3);
        chk(n_prog - p0 == 5, "R7 retries issued", n_prog - p0, 5);
        chk(n_clr - c0 == 2, "R7 status clears", n_clr - c0, 2);
        mem_ok(32'h020040, 3, 55, "R7 data");

        // R10 start while busy is ignored
        p0 = n_prog;
        run(32'h0A0020, 4, 77, 10);
        chk(r_err == 0 && r_cnt == 4, "R10 original result", r_cnt, 4);
        chk(n_prog - p0 == 4, "R10 no extra programs", n_prog - p0, 4);
        chk(sent - sent0 == 4, "R10 no extra bytes", sent - sent0, 4);
        mem_ok(32'h0A0020, 4, 77, "R10 data");

        // R8 verify mismatch
        corrupt_at = n_prog + 1;
        run(32'h0C0100, 3, 91, 0);
        corrupt_at = -1;
        chk(r_err == 2, "R8 verify error code", r_err, 2);
        chk(r_cnt == 0, "R8 zero count on mismatch", r_cnt, 0);

        // R7 block timeout after endless errors
        err_lo = n_prog; err_hi = 32'h7FFFFFFF;
        run(32'h0D0000, 2, 5, 0);
        err_hi = 0;
        chk(r_err == 1, "R7 block timeout code", r_err, 1);
        chk(r_cnt == 0, "R7 zero count on timeout", r_cnt, 0);
        chk(r_cyc >= BLOCK_TMO - 20, "R7 ran until block timer", r_cyc, BLOCK_TMO);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule